// File: doc/BRIEF.md
# Repeating-Value Moore Sequence Counter

This block is a free-running Moore state machine that produces a fixed, non-monotonic pattern on a 2-bit output. The pattern is 3, 2, 3, 1, 2, 3, and then it starts over. Several output values appear more than once in the pattern, so each output value cannot stand for a state by itself. The machine keeps a 3-bit binary phase register and derives the output from that register alone. It advances one phase on every clock edge.

The register can hold eight codes, but the pattern uses only the first six (phases 0 to 5). The two spare codes (6 and 7) put 0 on the output. From either spare code the machine goes back to phase 0 on the next edge. A synchronous, active-high reset also puts the machine in phase 0. There is no data stream, so there is no valid/ready handshake. The only pins are the clock, the reset and the pattern output.

Top module: `seq_moore_counter`

## Requirements
- R1: When `rst` is high at a rising edge, the phase register becomes 0, and `pattern_out` reads 3 after that edge. This holds whatever the phase was before.
- R2: When `rst` is low, each rising edge advances the phase by one. From phase 0 the output reads 3, 2, 3, 1, 2, 3 for phases 0 to 5.
- R3: Phase 5 is followed by phase 0, so the pattern repeats with a period of six clocks.
- R4: If the phase register holds a spare code (6 or 7) at a rising edge with `rst` low, it holds phase 0 after that edge, and `pattern_out` reads 3.
- R5: While the phase register holds code 6 or 7, `pattern_out` is 0.
- R6: `pattern_out` depends only on the stored phase. It changes only just after a rising edge and is stable for the rest of the cycle.
- R7: Reset takes priority over spare-code recovery. A spare code with `rst` high also goes to phase 0 and output 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pattern_out | output | 2 | Moore output decoded from the phase register |

## Verification
The bench walks several full periods of the pattern. It then resets the machine from each of the six phases in turn. A design with a wrong wrap or an off-by-one phase would drift out of step with the expected pattern. The bench places each spare code directly into the phase register and checks three things: the output reads 0 while the spare code is held, the output reads 3 after one edge, and the output reads 2 after the edge that follows. A design that let a spare code run on to another code, or that decoded a spare code as a pattern value, would fail one of these checks. The bench also repeats the spare-code case with reset held high, and it samples the output twice within each cycle to catch any output that changes away from the clock edge.

// File: rtl/seq_moore_pkg.sv
package seq_moore_pkg;
  localparam int unsigned PHASE_W = 3;
  localparam int unsigned VAL_W   = 2;
  localparam int unsigned SEQ_LEN = 6;
  localparam logic [PHASE_W-1:0] PHASE_START = '0;
  localparam logic [PHASE_W-1:0] PHASE_LAST  = PHASE_W'(SEQ_LEN - 1);

  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [VAL_W-1:0]   val_t;

  // Pattern value carried by each phase; spare codes give zero.
  function automatic val_t phase_value(input phase_t ph);
    val_t v;
    case (ph)
      3'd0:    v = 2'd3;
      3'd1:    v = 2'd2;
      3'd2:    v = 2'd3;
      3'd3:    v = 2'd1;
      3'd4:    v = 2'd2;
      3'd5:    v = 2'd3;
      default: v = 2'd0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/seq_moore_next.sv
module seq_moore_next
  import seq_moore_pkg::*;
(
  input  phase_t phase_q,
  output phase_t phase_d
);
  logic in_range;
  logic at_last;

  always_comb begin
    in_range = (phase_q < PHASE_LAST);
    at_last  = (phase_q == PHASE_LAST);
    if (in_range)
      phase_d = phase_q + phase_t'(1);
    else if (at_last)
      phase_d = PHASE_START;
    else
      phase_d = PHASE_START;  // spare code: back to the start
  end
endmodule

// File: rtl/seq_moore_reg.sv
module seq_moore_reg
  import seq_moore_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_d,
  output phase_t phase_q
);
  always_ff @(posedge clk) begin
    if (rst) phase_q <= PHASE_START;
    else     phase_q <= phase_d;
  end

  AST_RESET_START: assert property (@(posedge clk) disable iff (1'b0)
    rst |=> (phase_q == PHASE_START)); // R1
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (phase_q < PHASE_LAST) |-> (phase_d == phase_q + phase_t'(1))); // R2
  AST_WRAP_START: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PHASE_LAST) |-> (phase_d == PHASE_START)); // R3
  AST_SPARE_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (phase_q > PHASE_LAST) |-> (phase_d == PHASE_START)); // R4
endmodule

// File: rtl/seq_moore_decode.sv
module seq_moore_decode
  import seq_moore_pkg::*;
(
  input  phase_t phase_q,
  output val_t   value
);
  always_comb value = phase_value(phase_q);
endmodule

// File: rtl/seq_moore_counter.sv
module seq_moore_counter
  import seq_moore_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  output logic [VAL_W-1:0] pattern_out
);
  phase_t phase_q;
  phase_t phase_d;
  val_t   value;

  seq_moore_next u_next (
    .phase_q (phase_q),
    .phase_d (phase_d)
  );

  seq_moore_reg u_state (
    .clk     (clk),
    .rst     (rst),
    .phase_d (phase_d),
    .phase_q (phase_q)
  );

  seq_moore_decode u_dec (
    .phase_q (phase_q),
    .value   (value)
  );

  assign pattern_out = value;

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (phase_q > PHASE_LAST) |-> (pattern_out == '0)); // R5
  AST_SEQ_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (phase_q <= PHASE_LAST) |-> (pattern_out != '0)); // R2
  AST_START_THREE: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PHASE_START) |-> (pattern_out == 2'd3)); // R1
endmodule

// File: tb/test_seq_moore_counter.sv
module test_seq_moore_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pattern_out;
  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  seq_moore_counter i_seq_moore_counter (
    .clk         (clk),
    .rst         (rst),
    .pattern_out (pattern_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected value from the requirement list: 3,2,3,1,2,3.
  function automatic logic [1:0] exp_val(input int ph);
    int k = ph % 6;
    if (k == 3) return 2'd1;
    if (k == 1 || k == 4) return 2'd2;
    return 2'd3;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: pattern_out=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*4000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] early;
    rst = 1'b1;
    tick();
    tick();
    check("R1 reset state", pattern_out, 2'd3);
    rst = 1'b0;
    // R2/R3/R6: three full periods, sampled early and late in each cycle
    for (int c = 0; c < 18; c++) begin
      check(c == 0 ? "R2 start" : (c % 6 == 0 ? "R3 wrap" : "R2 step"), pattern_out, exp_val(c));
      early = pattern_out;
      #(CLK_PERIOD - 3);
      check("R6 stable in cycle", pattern_out, early);
      tick();
    end
    // R1: reset from every phase
    for (int p = 0; p < 6; p++) begin
      rst = 1'b1;
      tick();
      rst = 1'b0;
      for (int s = 0; s < p; s++) tick();
      check("R2 phase before reset", pattern_out, exp_val(p));
      rst = 1'b1;
      tick();
      check("R1 reset mid-pattern", pattern_out, 2'd3);
      rst = 1'b0;
      tick();
      check("R2 after reset", pattern_out, 2'd2);
    end
    // R4/R5: spare codes recover to the start
    for (int code = 6; code < 8; code++) begin
      tick();
      tick();
      force i_seq_moore_counter.u_state.phase_q = 3'(code);
      #1;
      check("R5 spare gives zero", pattern_out, 2'd0);
      @(negedge clk);
      release i_seq_moore_counter.u_state.phase_q;
      #1;
      check("R5 spare held", pattern_out, 2'd0);
      tick();
      check("R4 spare recovers", pattern_out, 2'd3);
      tick();
      check("R4 continues pattern", pattern_out, 2'd2);
    end
    // R7: reset with spare code
    for (int code = 6; code < 8; code++) begin
      tick();
      tick();
      force i_seq_moore_counter.u_state.phase_q = 3'(code);
      rst = 1'b1;
      @(negedge clk);
      release i_seq_moore_counter.u_state.phase_q;
      tick();
      check("R7 reset over spare", pattern_out, 2'd3);
      rst = 1'b0;
      tick();
      check("R7 resume", pattern_out, 2'd2);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule